// File: doc/BRIEF.md
# Dual-Mode 16-Bit Counter/Timer

This block holds a 16-bit preload that software writes one byte at a time, and a live 16-bit down-counter that moves once for each cycle in which the count-enable input `tick` is high. A mode input selects one of two behaviours. In timer mode the block runs without stopping and produces a square wave. In counter mode it counts down once from the preload and raises a flag when it reaches zero.

The `ready` flag is meant to feed an interrupt status bit. The `wave` output can act as a baud-rate clock source or drive a general-purpose pin. Start and stop commands are single-cycle pulses.

Reading the count is split into two steps. The low byte comes straight from the live counter. Reading it also captures the upper byte, so a later read of the upper byte matches the low byte that was taken earlier, even if the counter has moved since.

Top module: `ctmr16`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the upper preload byte when `wr_hi` is 1 and into the lower byte when `wr_hi` is 0. The other byte is left unchanged.
- R2: On the clock edge where `start` is high, the counter takes the preload value and `ready` clears. If `start` and `stop` arrive in the same cycle, `start` wins and the block runs. `wave` becomes 1 in timer mode and 0 in counter mode.
- R3: In counter mode (`timer_mode`=0), while running, each cycle with `tick` high decrements the count by one. A count of 0x0000 wraps to 0xFFFF.
- R4: In counter mode, the tick that takes the count from 1 to 0 sets `ready` and `wave`. Counting continues past zero until `stop`. `stop` freezes the count and clears `ready`.
- R5: In counter mode, a preload write made while counting does not change the running count. The new value is used at the next `start`.
- R6: In timer mode (`timer_mode`=1), when a tick finds the count at 1 or below, the count reloads from the preload and `wave` toggles. Any other tick decrements the count. A preload of N ≥ 1 therefore gives a `wave` period of 2·N ticks.
- R7: In timer mode, `ready` is set at every reload.
- R8: In timer mode, `stop` clears `ready` but the timer keeps counting and toggling.
- R9: In timer mode, `start` abandons the current half-period. It reloads the count from the preload, drives `wave` to 1 and clears `ready`.
- R10: With `rd_hi_sel`=0, `rd_data` shows the low byte of the live count. A cycle with `rd_lo_strobe` high captures the upper byte of the count. With `rd_hi_sel`=1, `rd_data` shows that captured byte.
- R11: After reset the count, preload, `ready` and `wave` are all 0 and the block is idle. Ticks received before the first `start` leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable, one step per high cycle |
| timer_mode | input | 1 | 1 = timer, 0 = counter |
| wr_en | input | 1 | Preload byte write strobe |
| wr_hi | input | 1 | Preload byte select: 1 upper, 0 lower |
| wr_data | input | 8 | Preload byte value |
| start | input | 1 | Start command pulse |
| stop | input | 1 | Stop command pulse |
| rd_lo_strobe | input | 1 | Low-byte read; captures upper byte |
| rd_hi_sel | input | 1 | Read select: 1 captured upper byte, 0 live low byte |
| rd_data | output | 8 | Read data |
| ready | output | 1 | Terminal count / wrap flag |
| wave | output | 1 | Square wave (timer) or terminal flag (counter) |

## Verification
The hardest case to set up is the captured upper byte going stale on purpose. The counter has to cross a byte boundary between the low-byte read and the upper-byte read. The stimulus preloads 0x0100, reads the low byte, then applies a single tick so the live count becomes 0x00FF while the captured byte must still read 0x01.

A second case that needs care is a timer stop landing mid-period. After the stop, the bench waits a full half-period and expects both a toggle and a fresh `ready`.

// File: rtl/ctmr16.sv
module ctmr16 #(
  parameter int CW = 16,
  localparam int HW = CW / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          timer_mode,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [HW-1:0] wr_data,
  input  logic          start,
  input  logic          stop,
  input  logic          rd_lo_strobe,
  input  logic          rd_hi_sel,
  output logic [HW-1:0] rd_data,
  output logic          ready,
  output logic          wave
);

  logic [CW-1:0] preload, cnt;
  logic [HW-1:0] hi_cap;
  logic          running, rdy_q, wave_q;
  logic          at_wrap, step;

  assign at_wrap = (cnt < CW'(2));
  assign step    = running && tick && !(stop && !timer_mode);
  assign rd_data = rd_hi_sel ? hi_cap : cnt[HW-1:0];
  assign ready   = rdy_q;
  assign wave    = wave_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      preload <= '0;
      cnt     <= '0;
      hi_cap  <= '0;
      running <= 1'b0;
      rdy_q   <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_hi) preload[CW-1:HW] <= wr_data;
        else       preload[HW-1:0]  <= wr_data;
      end
      if (rd_lo_strobe) hi_cap <= cnt[CW-1:HW];
      if (start) begin
        cnt     <= preload;
        running <= 1'b1;
        rdy_q   <= 1'b0;
        wave_q  <= timer_mode;
      end else begin
        if (step) begin
          if (timer_mode && at_wrap) begin
            cnt    <= preload;
            wave_q <= ~wave_q;
            rdy_q  <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
            if (!timer_mode && cnt == CW'(1)) begin
              rdy_q  <= 1'b1;
              wave_q <= 1'b1;
            end
          end
        end
        if (stop) begin
          rdy_q <= 1'b0;
          if (!timer_mode) running <= 1'b0;
        end
      end
    end
  end

  AST_STOP_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !ready); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && !timer_mode && tick && !start && !stop) |=> (cnt == CW'($past(cnt) - 1'b1))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(cnt)); // R11

  AST_TMR_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (running && timer_mode && !start) |=> running); // R8

  AST_WAVE_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (running && timer_mode && !start && !(tick && at_wrap)) |=> $stable(wave)); // R6

endmodule

// File: tb/ctmr16_tb.sv
`timescale 1ns/1ps
module ctmr16_tb;
  logic clk = 0, rst = 1, tick = 0, timer_mode = 0, wr_en = 0, wr_hi = 0;
  logic [7:0] wr_data = 0;
  logic start = 0, stop = 0, rd_lo_strobe = 0, rd_hi_sel = 0;
  logic [7:0] rd_data;
  logic ready, wave;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctmr16 u_dut (.clk(clk), .rst(rst), .tick(tick), .timer_mode(timer_mode),
    .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .start(start), .stop(stop),
    .rd_lo_strobe(rd_lo_strobe), .rd_hi_sel(rd_hi_sel), .rd_data(rd_data),
    .ready(ready), .wave(wave));

  typedef struct { int kind; logic [15:0] exp; string req; } item_t;
  item_t q[$];
  event ev;

  initial begin
    forever begin
      @ev;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? {15'd0, ready} : (it.kind == 1) ? {15'd0, wave} : {8'd0, rd_data};
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(int kind, logic [15:0] exp, string req);
    item_t it;
    #0.1;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    ->ev;
    #0.1;
  endtask

  task automatic wr(bit hi, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_hi = hi; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_preload(logic [15:0] v);
    wr(1, v[15:8]); wr(0, v[7:0]);
  endtask

  task automatic cmd_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic cmd_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic read_cnt(logic [15:0] exp, string req);
    @(negedge clk); rd_hi_sel = 0; rd_lo_strobe = 1;
    expect_item(2, {8'd0, exp[7:0]}, req);
    @(negedge clk); rd_lo_strobe = 0; rd_hi_sel = 1;
    expect_item(2, {8'd0, exp[15:8]}, req);
    rd_hi_sel = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    expect_item(0, 0, "R11 ready after reset");
    expect_item(1, 0, "R11 wave after reset");
    read_cnt(16'h0000, "R11 count after reset");
    ticks(3);
    read_cnt(16'h0000, "R11 ticks ignored when idle");

    set_preload(16'h1234);
    cmd_start();
    read_cnt(16'h1234, "R1 R2 preload bytes loaded");
    expect_item(0, 0, "R2 ready clear after start");
    expect_item(1, 0, "R2 wave low in counter mode");
    ticks(5);
    read_cnt(16'h122F, "R3 decrement per tick");

    set_preload(16'h0100);
    cmd_start();
    @(negedge clk); rd_hi_sel = 0; rd_lo_strobe = 1;
    expect_item(2, 16'h0000, "R10 live low byte");
    @(negedge clk); rd_lo_strobe = 0;
    ticks(1);
    rd_hi_sel = 1;
    expect_item(2, 16'h0001, "R10 captured upper byte stays");
    rd_hi_sel = 0;
    expect_item(2, 16'h00FF, "R10 live low byte after tick");

    set_preload(16'h0003);
    cmd_start();
    ticks(2);
    expect_item(0, 0, "R4 ready not before zero");
    ticks(1);
    expect_item(0, 1, "R4 ready at terminal count");
    expect_item(1, 1, "R4 wave at terminal count");
    read_cnt(16'h0000, "R4 count at zero");
    ticks(1);
    read_cnt(16'hFFFF, "R3 wrap 0 to FFFF");
    expect_item(0, 1, "R4 ready held while counting on");
    cmd_stop();
    expect_item(0, 0, "R4 stop clears ready");
    ticks(3);
    read_cnt(16'hFFFF, "R4 stop freezes count");

    @(negedge clk); start = 1; stop = 1;
    @(negedge clk); start = 0; stop = 0;
    ticks(1);
    read_cnt(16'h0002, "R2 start wins over stop");

    set_preload(16'h000A);
    cmd_start();
    ticks(2);
    wr(0, 8'h64);
    ticks(1);
    read_cnt(16'h0007, "R5 rewrite does not disturb count");
    cmd_stop();
    cmd_start();
    read_cnt(16'h0064, "R5 new preload at next start");
    cmd_stop();

    timer_mode = 1;
    set_preload(16'h0004);
    cmd_start();
    expect_item(1, 1, "R9 wave high at timer start");
    read_cnt(16'h0004, "R6 timer loaded");
    ticks(3);
    expect_item(1, 1, "R6 no toggle before wrap");
    expect_item(0, 0, "R7 no ready before wrap");
    ticks(1);
    expect_item(1, 0, "R6 toggle at wrap");
    expect_item(0, 1, "R7 ready at wrap");
    read_cnt(16'h0004, "R6 reload at wrap");
    ticks(4);
    expect_item(1, 1, "R6 period 2x preload");
    cmd_stop();
    expect_item(0, 0, "R8 stop clears ready");
    ticks(4);
    expect_item(1, 0, "R8 timer keeps toggling after stop");
    expect_item(0, 1, "R8 ready set again after stop");
    ticks(2);
    read_cnt(16'h0002, "R9 mid-cycle count");
    cmd_start();
    read_cnt(16'h0004, "R9 start reloads");
    expect_item(1, 1, "R9 wave high after restart");
    expect_item(0, 0, "R9 ready clear after restart");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule